// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block is the host-side master for a serial sampling converter. One request on `start_i` runs one frame. Chip select falls, and a 16-bit command word goes out on the data line while the sample word comes back from the converter. The serial clock is made from the system clock by a programmable half-period divider, and it rests high between frames.

The converter changes its output on falling serial-clock edges. Its first bit is already valid when chip select falls. The host therefore takes one sample just before the first falling edge, then one on each of the next fifteen rising edges. The 16 bits it gathers are split into a 3-bit channel number and a 13-bit sign-plus-magnitude result. These are published together with a one-cycle done pulse.

An abort input ends a frame early. When it does, the block reports the frame as aborted and leaves the previous result in place. After every frame, chip select stays high for a programmable number of system clocks before a new request is accepted.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `cs_no` and `sclk_o` are 1, and `busy_o`, `done_o`, `aborted_o`, `chan_o` and `result_o` are 0.
- R2: After a start is accepted, `cs_no` stays low for exactly 32*H system clocks and `sclk_o` makes exactly 16 falling edges. H is `div_i` latched at the start, with 0 treated as 1. `sclk_o` is high whenever `cs_no` is high.
- R3: The command is sent MSB first. `cmd_i[15]` is on `din_o` from the fall of `cs_no`, and each later bit changes only on a rising `sclk_o` edge. The converter therefore reads `cmd_i[16-k]` at falling edge k.
- R4: `dout_i` is sampled once at the end of the first high half-period, then once at rising edges 1 to 15, giving bits b15..b0 in arrival order. `chan_o` = b15:b13 and `result_o` = b12:b0, where b12 is the sign and b11:b0 the magnitude.
- R5: `done_o` is high for one system clock, starting at the edge where `cs_no` rises after a full frame. `chan_o` and `result_o` change only at that edge.
- R6: If `abort_i` is high in a clock where a frame runs, `cs_no` and `sclk_o` go high at that edge. `aborted_o` then pulses for one clock, `done_o` stays low, and `chan_o` and `result_o` keep their values.
- R7: `busy_o` falls Q+1 system clocks after `cs_no` rises. Q is `quiet_i` latched at the start.
- R8: `busy_o` rises at the edge that accepts a start. A start seen while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, taken when idle |
| cmd_i | input | 16 | Command word sent MSB first |
| div_i | input | HALF_W | Serial clock half-period in system clocks (0 acts as 1) |
| quiet_i | input | QUIET_W | Idle count after a frame |
| abort_i | input | 1 | Ends the running frame early |
| dout_i | input | 1 | Serial data from converter |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial data to converter |
| busy_o | output | 1 | Frame or quiet period in progress |
| done_o | output | 1 | One-cycle pulse when a full frame's result is valid |
| aborted_o | output | 1 | One-cycle pulse when a frame is aborted |
| chan_o | output | 3 | Channel number of last full frame |
| result_o | output | 13 | Sign bit and 12-bit magnitude of last full frame |

## Verification
The bench builds the block with its default widths, HALF_W = 8 and QUIET_W = 8. It drives divider settings from 0 to 3. This covers the fastest serial clock, where one half-period is a single system clock and each sample follows a data change by exactly one clock, and it also exercises the clamp of 0 to 1. Quiet counts from 0 to 5 test the shortest turnaround and several longer idle gaps. The abort case uses a two-clock half-period so that the frame is cut partway through its bits.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned PHASES     = 2 * FRAME_BITS;
  localparam int unsigned PH_W       = $clog2(PHASES);
  localparam int unsigned CH_W       = 3;
  localparam int unsigned RES_W      = FRAME_BITS - CH_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } state_e;
endpackage

// File: rtl/adc_sclk_timer.sv
module adc_sclk_timer #(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned PH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o,
  output logic [PH_W-1:0]   phase_o
);
  logic [HALF_W-1:0] half_q, cnt_q;
  logic [PH_W-1:0]   phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= '0;
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (load_i) begin
      half_q  <= half_i;
      cnt_q   <= half_i - HALF_W'(1);
      phase_q <= '0;
    end else if (run_i) begin
      if (cnt_q == '0) begin
        cnt_q   <= half_q - HALF_W'(1);
        phase_q <= phase_q + PH_W'(1);
      end else begin
        cnt_q <= cnt_q - HALF_W'(1);
      end
    end
  end

  assign tick_o  = run_i && (cnt_q == '0);
  assign phase_o = phase_q;
endmodule

// File: rtl/adc_serial_shift.sv
module adc_serial_shift #(
  parameter int unsigned BITS = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            clr_i,
  input  logic [BITS-1:0] cmd_i,
  input  logic            drive_i,
  input  logic            sample_i,
  input  logic            dout_i,
  output logic            din_o,
  output logic [BITS-1:0] rx_o
);
  logic [BITS-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= cmd_i;
      else if (clr_i)   tx_q <= '0;
      else if (drive_i) tx_q <= {tx_q[BITS-2:0], 1'b0};
      if (sample_i)     rx_q <= {rx_q[BITS-2:0], dout_i};
    end
  end

  assign din_o = tx_q[BITS-1];
  assign rx_o  = rx_q;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int unsigned HALF_W  = 8,
  parameter int unsigned QUIET_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [15:0]        cmd_i,
  input  logic [HALF_W-1:0]  div_i,
  input  logic [QUIET_W-1:0] quiet_i,
  input  logic               abort_i,
  input  logic               dout_i,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               din_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               aborted_o,
  output logic [CH_W-1:0]    chan_o,
  output logic [RES_W-1:0]   result_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  state_e             state_q;
  logic               cs_q, sclk_q, done_q, abort_q;
  logic [CH_W-1:0]    chan_q;
  logic [RES_W-1:0]   res_q;
  logic [QUIET_W-1:0] qcnt_q;
  logic [HALF_W-1:0]  half_eff;
  logic [PH_W-1:0]    phase;
  logic [FRAME_BITS-1:0] rx;
  logic tick, in_frame, accept, abort_hit, step, last;

  assign half_eff  = (div_i == '0) ? HALF_W'(1) : div_i;
  assign in_frame  = (state_q == ST_FRAME);
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign abort_hit = in_frame && abort_i;
  assign step      = tick && !abort_i;
  assign last      = (phase == LAST_PH);

  adc_sclk_timer #(.HALF_W(HALF_W), .PH_W(PH_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .run_i   (in_frame),
    .half_i  (half_eff),
    .tick_o  (tick),
    .phase_o (phase)
  );

  // first sample precedes falling edge 1; others ride rising edges 1..15
  adc_serial_shift #(.BITS(FRAME_BITS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .clr_i    (abort_hit),
    .cmd_i    (cmd_i),
    .drive_i  (step && phase[0]),
    .sample_i (step && ((phase == '0) || (phase[0] && !last))),
    .dout_i   (dout_i),
    .din_o    (din_o),
    .rx_o     (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      chan_q  <= '0;
      res_q   <= '0;
      qcnt_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_FRAME;
          cs_q    <= 1'b0;
          sclk_q  <= 1'b1;
          qcnt_q  <= quiet_i;
        end
        ST_FRAME: if (abort_i) begin
          cs_q    <= 1'b1;
          sclk_q  <= 1'b1;
          abort_q <= 1'b1;
          state_q <= ST_QUIET;
        end else if (tick) begin
          sclk_q <= phase[0];
          if (last) begin
            cs_q    <= 1'b1;
            done_q  <= 1'b1;
            chan_q  <= rx[FRAME_BITS-1 -: CH_W];
            res_q   <= rx[RES_W-1:0];
            state_q <= ST_QUIET;
          end
        end
        ST_QUIET: begin
          if (qcnt_q == '0) state_q <= ST_IDLE;
          else              qcnt_q  <= qcnt_q - QUIET_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no     = cs_q;
  assign sclk_o    = sclk_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign aborted_o = abort_q;
  assign chan_o    = chan_q;
  assign result_o  = res_q;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int unsigned RES_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_no,
  input logic             sclk_o,
  input logic             din_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             aborted_o,
  input logic [RES_W-1:0] result_o
);
  p_sclk_rests_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
  p_din_held_at_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(din_o));
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_at_cs_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_no));
  p_result_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  p_abort_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && aborted_o));
  p_abort_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aborted_o |=> !aborted_o);
  p_abort_releases_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aborted_o |-> (cs_no && sclk_o && busy_o));
  p_busy_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.RES_W(13)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_no     (cs_no),
  .sclk_o    (sclk_o),
  .din_o     (din_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .aborted_o (aborted_o),
  .result_o  (result_o)
);

// File: tb/adc_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0;
  logic [15:0] cmd = '0;
  logic [7:0]  div = 8'd1, quiet = '0;
  logic        dout;
  logic        cs_n, sclk, din, busy, done, aborted;
  logic [2:0]  chan;
  logic [12:0] result;

  logic [15:0] slv_word = '0;
  logic [15:0] slv_rx = '0;
  int          slv_falls = 0;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  adc_frame_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .div_i(div),
    .quiet_i(quiet), .abort_i(abort), .dout_i(dout), .cs_no(cs_n),
    .sclk_o(sclk), .din_o(din), .busy_o(busy), .done_o(done),
    .aborted_o(aborted), .chan_o(chan), .result_o(result)
  );

  // converter model: bit k on dout after falling edge k, din read on falling edges
  always @(negedge cs_n or negedge sclk) begin
    if (sclk) begin
      slv_falls = 0;
      slv_rx    = '0;
    end else if (!cs_n) begin
      slv_rx = {slv_rx[14:0], din};
      slv_falls++;
    end
  end
  assign dout = (cs_n || slv_falls > 15) ? 1'b0 : slv_word[15 - slv_falls];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // {cmd, converter word, divider, quiet}
  localparam logic [47:0] VEC [4] = '{
    {16'hA5C3, 16'h7FFF, 8'd1, 8'd0},
    {16'h1234, 16'h8001, 8'd2, 8'd3},
    {16'hFFFF, 16'h5A5A, 8'd3, 8'd1},
    {16'h8001, 16'hC5A1, 8'd0, 8'd5}
  };

  task automatic kick(input logic [15:0] c, input logic [15:0] w,
                      input logic [7:0] d, input logic [7:0] q);
    @(negedge clk);
    cmd = c; slv_word = w; div = d; quiet = q; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_full(input logic [15:0] c, input logic [15:0] w,
                          input logic [7:0] d, input logic [7:0] q);
    int h = (d == 0) ? 1 : int'(d);
    int n = 0, m = 0;
    kick(c, w, d, q);
    while (!cs_n && n < 2000) begin n++; @(negedge clk); end
    chk(n == 32 * h, "R2 frame length", n, 32 * h);
    chk(slv_falls == 16, "R2 falling edges", slv_falls, 16);
    chk(slv_rx == c, "R3 command bits", int'(slv_rx), int'(c));
    chk(done == 1'b1, "R5 done at cs rise", int'(done), 1);
    chk(chan == w[15:13], "R4 channel", int'(chan), int'(w[15:13]));
    chk(result == w[12:0], "R4 result", int'(result), int'(w[12:0]));
    while (busy && m < 2000) begin
      m++; @(negedge clk);
      if (m == 1) chk(done == 1'b0, "R5 done one cycle", int'(done), 0);
    end
    chk(m == int'(q) + 1, "R7 quiet length", m, int'(q) + 1);
  endtask

  initial begin
    #(4ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && sclk, "R1 lines high in reset", int'({cs_n, sclk}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && !busy, "R1 idle after reset", int'({cs_n, sclk, busy}), 6);
    chk(!done && !aborted, "R1 pulses low", int'({done, aborted}), 0);
    chk(chan == 0 && result == 0, "R1 outputs cleared", int'(result), 0);

    for (int i = 0; i < 4; i++)
      run_full(VEC[i][47:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

    // R8: busy at acceptance, second start ignored
    kick(16'h3C5A, 16'h2468, 8'd1, 8'd2);
    chk(busy && !cs_n, "R8 busy after start", int'(busy), 1);
    repeat (4) @(negedge clk);
    cmd = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(slv_rx == 16'h3C5A, "R8 first command kept", int'(slv_rx), 16'h3C5A);
    chk(result == 13'h0468, "R8 first result kept", int'(result), 13'h0468);
    begin
      int lows = 0;
      repeat (40) begin @(negedge clk); if (!cs_n) lows++; end
      chk(lows == 0, "R8 no second frame", lows, 0);
    end

    // R6: abort mid-frame
    kick(16'h0F0F, 16'hFFFF, 8'd2, 8'd1);
    repeat (20) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_n && sclk, "R6 lines released", int'({cs_n, sclk}), 3);
    chk(aborted && !done, "R6 aborted pulse", int'({aborted, done}), 2);
    @(negedge clk);
    chk(!aborted, "R6 aborted one cycle", int'(aborted), 0);
    chk(result == 13'h0468 && chan == 3'd1, "R6 result unchanged", int'(result), 13'h0468);
    begin
      int m = 1;
      while (busy && m < 100) begin m++; @(negedge clk); end
      chk(m == 2, "R7 quiet after abort", m, 2);
    end
    chk(!done, "R6 no done", int'(done), 0);

    summary();
  end
endmodule